// File: doc/BRIEF.md
# Passthrough Command Filter and Bit Swapper

This block sits in the byte-serial path that carries SPI traffic from an upstream host to a downstream flash device. The first byte of each transaction is the opcode. The block looks that opcode up in a 256-entry drop bitmap. A dropped command never selects the downstream device, and none of its bytes go out. An admitted command is forwarded byte by byte, and two kinds of substitution can be applied on the way.

For read commands that have address swapping enabled, selected address bits are forced to preset values. For single-lane write commands that have payload swapping enabled, selected bits of the first four payload bytes are forced to preset values.

A command decoder supplies the per-command attributes combinationally, alongside the opcode byte. These attributes are the address mode, the two swap enables, the payload lane mask and the payload direction. The block latches them when it accepts the opcode. Each output byte is produced in the same cycle as its input byte.

Top module: `pt_cmd_guard`

## Requirements
- R1: If bit `v` of `filter_map` is 1 and the opcode byte has value `v`, the command is dropped. `ds_sel` and `byte_out_valid` stay 0 from the opcode byte until `cs_active` falls.
- R2: For an admitted opcode, `ds_sel` rises in the cycle of the opcode byte and stays 1 until `cs_active` falls. The opcode byte is forwarded unchanged.
- R3: `cmd_addr_mode` selects the address length: 0 means no address, 1 means 4 bytes when `cfg_addr_4b`=1 and otherwise 3 bytes, 2 means 3 bytes, and 3 means 4 bytes. Address bytes arrive most significant first, directly after the opcode.
- R4: With `cmd_addr_swap` set, each address output bit is `addr_data` where `addr_mask` is 1 and the input bit where it is 0. Address byte k uses bits [31-8k -: 8] in 4-byte mode and bits [23-8k -: 8] in 3-byte mode, so mask and data bits [31:24] have no effect in 3-byte mode.
- R5: When payload swap is active, payload byte p (p = 0..3, counted from the first byte after the address) is merged with bits [8p+7:8p] of `pay_mask`/`pay_data`, using the same rule as R4.
- R6: Payload swap is active only when `cmd_pay_swap` is 1, `cmd_lanes` is 4'b0001 and `cmd_dir_out` is 1 (toward the flash). Any other combination leaves the payload unchanged.
- R7: Payload bytes after the fourth, the address bytes of commands without address swap, and the payload of commands without active payload swap are forwarded unchanged.
- R8: `byte_out_valid` and `byte_out` respond in the same cycle as `byte_valid`/`byte_in`, with no added latency.
- R9: After reset, and whenever `cs_active` is 0, `ds_sel` is 0 and the next byte received with `cs_active` high is taken as a new opcode. This includes a transaction that is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_active | input | 1 | Upstream transaction in progress |
| byte_valid | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Upstream byte |
| filter_map | input | 256 | Drop bitmap indexed by opcode |
| cfg_addr_4b | input | 1 | Global 4-byte address setting |
| addr_mask | input | 32 | Address bits to replace |
| addr_data | input | 32 | Replacement address bits |
| pay_mask | input | 32 | Payload bits to replace, first byte in [7:0] |
| pay_data | input | 32 | Replacement payload bits |
| cmd_addr_mode | input | 2 | Address mode of the incoming opcode |
| cmd_addr_swap | input | 1 | Address swap enable for the opcode |
| cmd_pay_swap | input | 1 | Payload swap enable for the opcode |
| cmd_lanes | input | 4 | Payload lane mask of the opcode |
| cmd_dir_out | input | 1 | 1 = payload goes toward the flash |
| byte_out | output | 8 | Downstream byte |
| byte_out_valid | output | 1 | `byte_out` is forwarded this cycle |
| ds_sel | output | 1 | Downstream chip-select enable |

## Verification
A wrong phase or byte index shows up at the ports within one byte slot. The mask is then applied one byte too early or too late, or it lands on the wrong lane of the swap word. That produces a wrong `byte_out` on the very byte where the phase is off. A wrong drop decision shows on `ds_sel` in the opcode cycle itself. A wrong latched attribute, such as the address length or the payload-swap qualification, becomes visible at the first address or payload byte of that command. Because of this, a sweep over every opcode, every address mode and every lane/direction pair exposes each such fault within the command that triggers it.

// File: rtl/pt_guard_pkg.sv
package pt_guard_pkg;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DROP = 2'd3
  } phase_e;

  // Forced bits come from data, the rest from the source byte.
  function automatic logic [7:0] merge_bits(input logic [7:0] src,
                                            input logic [7:0] msk,
                                            input logic [7:0] dat);
    return (src & ~msk) | (dat & msk);
  endfunction

  // Address length in bytes for a decoder mode and the global 4-byte setting.
  function automatic logic [2:0] addr_len(input logic [1:0] mode,
                                          input logic cfg4);
    case (mode)
      2'd0:    return 3'd0;
      2'd1:    return cfg4 ? 3'd4 : 3'd3;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // Lane of a 32-bit word matching address byte k (k = 0 is sent first).
  function automatic logic [7:0] addr_lane(input logic [31:0] w,
                                           input logic [2:0] k,
                                           input logic four);
    logic [2:0] pos;
    pos = (four ? 3'd3 : 3'd2) - k;
    return 8'(w >> {pos[1:0], 3'b000});
  endfunction

  // Lane of a 32-bit word for payload byte p, little-endian.
  function automatic logic [7:0] pay_lane(input logic [31:0] w,
                                          input logic [1:0] p);
    return 8'(w >> {p, 3'b000});
  endfunction

endpackage

// File: rtl/pt_opc_filter.sv
module pt_opc_filter #(
  parameter int OPC_W = 8,
  localparam int MAP_N = 1 << OPC_W
) (
  input  logic [MAP_N-1:0] map,
  input  logic [OPC_W-1:0] opc,
  output logic             hit
);
  assign hit = map[opc];
endmodule

// File: rtl/pt_seq_track.sv
module pt_seq_track
  import pt_guard_pkg::*;
#(
  parameter int PAY_N = 4,
  localparam int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             byte_valid,
  input  logic             opc_hit,
  input  logic [1:0]       cmd_addr_mode,
  input  logic             cfg_addr_4b,
  input  logic             cmd_addr_swap,
  input  logic             cmd_pay_swap,
  input  logic [3:0]       cmd_lanes,
  input  logic             cmd_dir_out,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx,
  output logic             four_q,
  output logic             asw_q,
  output logic             psw_q,
  output logic             opc_strobe
);
  logic [2:0] nab_now;
  logic [2:0] nab_q;
  logic       psw_ok;

  assign nab_now    = addr_len(cmd_addr_mode, cfg_addr_4b);
  assign psw_ok     = cmd_pay_swap && (cmd_lanes == 4'b0001) && cmd_dir_out;
  assign opc_strobe = cs_active && byte_valid && (phase == PH_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OPC;
      idx    <= '0;
      four_q <= 1'b0;
      asw_q  <= 1'b0;
      psw_q  <= 1'b0;
      nab_q  <= '0;
    end else if (!cs_active) begin
      phase <= PH_OPC;
      idx   <= '0;
    end else if (byte_valid) begin
      case (phase)
        PH_OPC: begin
          idx    <= '0;
          four_q <= (nab_now == 3'd4);
          asw_q  <= cmd_addr_swap;
          psw_q  <= psw_ok;
          nab_q  <= nab_now;
          if (opc_hit)              phase <= PH_DROP;
          else if (nab_now != 3'd0) phase <= PH_ADDR;
          else                      phase <= PH_DATA;
        end
        PH_ADDR: begin
          if (idx == nab_q - 3'd1) begin
            phase <= PH_DATA;
            idx   <= '0;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        PH_DATA: begin
          if (idx != IDX_W'(PAY_N)) idx <= idx + 3'd1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pt_byte_swap.sv
module pt_byte_swap
  import pt_guard_pkg::*;
#(
  parameter int PAY_N = 4
) (
  input  phase_e      phase,
  input  logic [2:0]  idx,
  input  logic        four_q,
  input  logic        asw_q,
  input  logic        psw_q,
  input  logic [7:0]  byte_in,
  input  logic [31:0] addr_mask,
  input  logic [31:0] addr_data,
  input  logic [31:0] pay_mask,
  input  logic [31:0] pay_data,
  output logic [7:0]  byte_out,
  output logic        addr_slot,
  output logic        pay_slot
);
  assign addr_slot = (phase == PH_ADDR) && asw_q;
  assign pay_slot  = (phase == PH_DATA) && psw_q && (idx < 3'(PAY_N));

  always_comb begin
    if (addr_slot)
      byte_out = merge_bits(byte_in, addr_lane(addr_mask, idx, four_q),
                            addr_lane(addr_data, idx, four_q));
    else if (pay_slot)
      byte_out = merge_bits(byte_in, pay_lane(pay_mask, idx[1:0]),
                            pay_lane(pay_data, idx[1:0]));
    else
      byte_out = byte_in;
  end
endmodule

// File: rtl/pt_cmd_guard.sv
module pt_cmd_guard
  import pt_guard_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int SWAP_W = 32,
  localparam int MAP_N = 1 << OPC_W,
  localparam int PAY_N = SWAP_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  input  logic [MAP_N-1:0] filter_map,
  input  logic             cfg_addr_4b,
  input  logic [31:0]      addr_mask,
  input  logic [31:0]      addr_data,
  input  logic [31:0]      pay_mask,
  input  logic [31:0]      pay_data,
  input  logic [1:0]       cmd_addr_mode,
  input  logic             cmd_addr_swap,
  input  logic             cmd_pay_swap,
  input  logic [3:0]       cmd_lanes,
  input  logic             cmd_dir_out,
  output logic [7:0]       byte_out,
  output logic             byte_out_valid,
  output logic             ds_sel
);
  phase_e     phase;
  logic [2:0] idx;
  logic       four_q, asw_q, psw_q;
  // Internal events brought out for the checker.
  logic       opc_strobe, opc_hit, addr_slot, pay_slot;

  pt_opc_filter #(.OPC_W(OPC_W)) filt_i (
    .map (filter_map),
    .opc (byte_in[OPC_W-1:0]),
    .hit (opc_hit)
  );

  pt_seq_track #(.PAY_N(PAY_N)) seq_i (
    .clk, .rst_n, .cs_active, .byte_valid, .opc_hit,
    .cmd_addr_mode, .cfg_addr_4b, .cmd_addr_swap, .cmd_pay_swap,
    .cmd_lanes, .cmd_dir_out,
    .phase, .idx, .four_q, .asw_q, .psw_q, .opc_strobe
  );

  pt_byte_swap #(.PAY_N(PAY_N)) swap_i (
    .phase, .idx, .four_q, .asw_q, .psw_q, .byte_in,
    .addr_mask, .addr_data, .pay_mask, .pay_data,
    .byte_out, .addr_slot, .pay_slot
  );

  // Select opens on an admitted opcode and stays open through the command.
  assign ds_sel = cs_active &&
                  (opc_strobe ? !opc_hit
                              : (phase == PH_ADDR || phase == PH_DATA));
  assign byte_out_valid = ds_sel && byte_valid;
endmodule

// File: rtl/pt_cmd_guard_chk.sv
module pt_cmd_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_active,
  input logic        byte_valid,
  input logic [7:0]  byte_in,
  input logic [7:0]  byte_out,
  input logic        byte_out_valid,
  input logic        ds_sel,
  input logic [31:0] addr_mask,
  input logic        opc_strobe,
  input logic        opc_hit,
  input logic        addr_slot,
  input logic        pay_slot
);
  a_r1_drop_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_strobe && opc_hit) |-> (!ds_sel && !byte_out_valid));
  a_r1_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_strobe && opc_hit) |=> !ds_sel);
  a_r1_no_sel_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_sel |-> !byte_out_valid);
  a_r2_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_sel && cs_active) |=> (ds_sel || !cs_active));
  a_r4_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_out_valid && addr_slot && addr_mask == 32'd0) |-> byte_out == byte_in);
  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_out_valid && !addr_slot && !pay_slot) |-> byte_out == byte_in);
  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_out_valid |-> (byte_valid && cs_active));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !ds_sel);
endmodule

bind pt_cmd_guard pt_cmd_guard_chk chk_i (
  .clk, .rst_n, .cs_active, .byte_valid, .byte_in, .byte_out,
  .byte_out_valid, .ds_sel, .addr_mask, .opc_strobe, .opc_hit,
  .addr_slot, .pay_slot
);

// File: tb/pt_cmd_guard_tb_top.sv
module pt_cmd_guard_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_active = 1'b0;
  logic         byte_valid = 1'b0;
  logic [7:0]   byte_in = '0;
  logic [255:0] filter_map;
  logic         cfg_addr_4b = 1'b0;
  logic [31:0]  addr_mask = '0, addr_data = '0, pay_mask = '0, pay_data = '0;
  logic [1:0]   cmd_addr_mode = '0;
  logic         cmd_addr_swap = 1'b0, cmd_pay_swap = 1'b0, cmd_dir_out = 1'b0;
  logic [3:0]   cmd_lanes = '0;
  logic [7:0]   byte_out;
  logic         byte_out_valid, ds_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pt_cmd_guard dut_i (
    .clk, .rst_n, .cs_active, .byte_valid, .byte_in, .filter_map,
    .cfg_addr_4b, .addr_mask, .addr_data, .pay_mask, .pay_data,
    .cmd_addr_mode, .cmd_addr_swap, .cmd_pay_swap, .cmd_lanes,
    .cmd_dir_out, .byte_out, .byte_out_valid, .ds_sel
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drop pattern: opcodes with value mod 7 == 3, plus 0xFF.
  function automatic bit drop_of(input int v);
    return ((v % 7) == 3) || (v == 255);
  endfunction

  // Sends opcode then up to nsend bytes (address first, then payload).
  task automatic run_cmd(input logic [7:0] opc, input logic [1:0] mode,
                         input bit cfg4, input bit asw, input bit psw,
                         input logic [3:0] lanes, input bit dout,
                         input logic [31:0] addr, input int nsend,
                         input logic [7:0] pbase);
    bit four, drop, pen;
    int nab;
    logic [31:0] am, aw, pw, pm_w;
    four = (mode == 2'd3) || (mode == 2'd1 && cfg4);
    nab  = (mode == 2'd0) ? 0 : (four ? 4 : 3);
    drop = drop_of(opc);
    pen  = psw && (lanes == 4'b0001) && dout;
    am   = four ? addr_mask : (addr_mask & 32'h00FF_FFFF);
    aw   = asw ? ((addr & ~am) | (addr_data & am)) : addr;
    pw   = {pbase + 8'd3, pbase + 8'd2, pbase + 8'd1, pbase};
    pm_w = (pw & ~pay_mask) | (pay_data & pay_mask);
    @(negedge clk);
    cmd_addr_mode = mode; cfg_addr_4b = cfg4; cmd_addr_swap = asw;
    cmd_pay_swap = psw; cmd_lanes = lanes; cmd_dir_out = dout;
    cs_active = 1'b1; byte_valid = 1'b1; byte_in = opc;
    #1;
    chk(ds_sel == !drop, drop ? "R1 drop select" : "R2 select on opcode", ds_sel, !drop);
    chk(byte_out_valid == !drop, "R8 opcode valid same cycle", byte_out_valid, !drop);
    if (!drop) chk(byte_out == opc, "R2 opcode unchanged", byte_out, opc);
    for (int i = 0; i < nsend; i++) begin
      logic [7:0] b, e;
      if (i < nab) begin
        b = 8'(addr >> (8 * (nab - 1 - i)));
        e = 8'(aw >> (8 * (nab - 1 - i)));
      end else begin
        int p;
        p = i - nab;
        b = pbase + 8'(p);
        e = (pen && p < 4) ? 8'(pm_w >> (8 * p)) : b;
      end
      @(negedge clk);
      byte_in = b;
      #1;
      if (drop) begin
        chk(!ds_sel && !byte_out_valid, "R1 dropped stays closed", {ds_sel, byte_out_valid}, 0);
      end else begin
        chk(ds_sel && byte_out_valid, "R2 select held", {ds_sel, byte_out_valid}, 3);
        chk(byte_out == e,
            (i < nab) ? (asw ? "R4 address swap" : "R3 address pass") :
            (pen ? "R5 payload swap" : (psw ? "R6 payload swap gated" : "R7 payload pass")),
            byte_out, e);
      end
    end
    @(negedge clk);
    byte_valid = 1'b0; cs_active = 1'b0;
    #1;
    chk(!ds_sel && !byte_out_valid, "R9 idle after transaction", ds_sel, 0);
  endtask

  initial begin
    for (int v = 0; v < 256; v++) filter_map[v] = drop_of(v);
    #7;
    chk(!ds_sel && !byte_out_valid, "R9 reset state", {ds_sel, byte_out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cs_active = 1'b1;
    #1;
    chk(!ds_sel, "R9 no select before opcode", ds_sel, 0);
    cs_active = 1'b0;

    // Every opcode, no address, two payload bytes.
    for (int v = 0; v < 256; v++)
      run_cmd(8'(v), 2'd0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1, 32'h0, 2, 8'(v));

    // Address modes, global width and swap enable; top mask byte set.
    addr_mask = 32'hFF0F_00F1; addr_data = 32'hA5C3_5A3C;
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 2; s++)
          run_cmd(8'h0B, 2'(m), c[0], s[0], 1'b0, 4'b0001, 1'b1,
                  32'h1234_5678 + 32'(m * 16 + c * 4 + s), 10, 8'h40);

    // Zero mask leaves the address intact.
    addr_mask = 32'h0;
    run_cmd(8'h0C, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1, 32'hDEAD_BEEF, 6, 8'h10);

    // Payload swap over every lane mask and direction.
    addr_mask = 32'h00FF_0000; addr_data = 32'h0011_0000;
    pay_mask = 32'h0FF0_33CC; pay_data = 32'h1234_ABCD;
    for (int l = 0; l < 16; l++)
      for (int d = 0; d < 2; d++)
        run_cmd(8'h02, 2'd2, 1'b0, 1'b1, 1'b1, 4'(l), d[0],
                32'h0055_6677, 10, 8'(8'h80 + l));

    // Payload swap without an address phase; no swap when disabled.
    run_cmd(8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 4'b0001, 1'b1, 32'h0, 7, 8'hF8);
    run_cmd(8'h05, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1, 32'h0, 7, 8'hF8);

    // Cut-short command, then a fresh one is parsed from its opcode.
    addr_mask = 32'hFFFF_FFFF; addr_data = 32'h0102_0304;
    run_cmd(8'h0B, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1, 32'hAAAA_AAAA, 2, 8'h00);
    run_cmd(8'h0B, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1, 32'h5555_5555, 6, 8'h20);
    run_cmd(8'h03, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b1, 32'h5555_5555, 4, 8'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule